// File: doc/BRIEF.md
# CAN Fault-Confinement State Tracker

This block follows the error condition of a CAN controller. Each time the controller's error-flag byte is sampled, the block reduces the byte to one of four bus levels: active, warning, passive or bus-off. It holds that level in a register and keeps saturating counts of entries into the warning and passive levels, plus a count of receive-buffer overflows. The CAN protocol engine that produces the flags is outside this block.

The block emits an error-event record, made of a valid strobe, class bits and detail bits, on a sample that arrives with the error-interrupt strobe high. It also emits one on the first sample after a restart. Each accepted sample is followed one cycle later by a write-back pulse that clears the flag byte at its source. If bus-off is reached while automatic restart is disabled, the block raises a sleep request and stops tracking until a restart request arrives.

Top module: `can_fc_tracker`

## Requirements
- R1: On an accepted sample (`flag_valid` high, no sleep, no restart), `bus_state` takes a new value on the next cycle. It is 3 (bus-off) if bit 5 is set. Otherwise it is 2 (passive) if bit 4 (TX passive) or bit 3 (RX passive) is set. Otherwise it is 1 (warning) if bit 2 (TX warning) or bit 1 (RX warning) is set. Otherwise it is 0 (active). Bits 0, 6 and 7 do not affect the level.
- R2: `warn_cnt` increments by one when an accepted sample moves the level from 0 to any of 1, 2 or 3.
- R3: `pass_cnt` increments by one when an accepted sample moves the level from 0 or 1 to 2 or 3. A jump from 0 straight to 2 or 3 therefore increments both `warn_cnt` and `pass_cnt`.
- R4: `ovf_cnt` grows by the number of set bits among flag bits 6 and 7 on each accepted sample.
- R5: All three counters saturate at their all-ones value instead of wrapping.
- R6: `evt_valid` pulses on the cycle after an accepted sample taken with `err_irq` high or with a restart pending. `evt_class` carries bit 2 = restart, bit 1 = bus-off, and bit 0 = controller cause (set when the detail is non-zero). `evt_detail` sets exactly one level-cause bit, for the cause that won the priority: bit 0 RX warning, bit 1 TX warning, bit 2 RX passive, bit 3 TX passive. The bus-off level sets none of these. `evt_detail` bit 4 is set when either overflow bit is set.
- R7: `restart_req` forces `bus_state` to 0 and clears `sleep_req` on the next cycle. A sample presented in the same cycle is ignored. The next accepted sample produces an event with the restart class bit set, even when `err_irq` is low.
- R8: `flag_clear` pulses for one cycle, on the cycle after each accepted sample and at no other time.
- R9: When an accepted sample yields bus-off while `auto_restart_en` is low, `sleep_req` rises on the next cycle and stays high. Until a restart arrives, later samples have no effect on state, counters, events or `flag_clear`.
- R10: When `auto_restart_en` is high, bus-off never raises `sleep_req`, and later samples keep being tracked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_valid | input | 1 | Flag byte is sampled this cycle |
| flag_byte | input | 8 | Error-flag byte from the controller |
| err_irq | input | 1 | Error-interrupt flag accompanying the sample |
| restart_req | input | 1 | Restart request |
| auto_restart_en | input | 1 | Automatic recovery from bus-off enabled |
| bus_state | output | 2 | Current level: 0 active, 1 warning, 2 passive, 3 bus-off |
| warn_cnt | output | CNT_W | Entries into warning or worse |
| pass_cnt | output | CNT_W | Entries into passive or worse |
| ovf_cnt | output | OVF_W | Overflow bits seen |
| evt_valid | output | 1 | Error-event strobe |
| evt_class | output | 3 | Event class: restart, bus-off, controller |
| evt_detail | output | 5 | Event detail bits |
| sleep_req | output | 1 | Sleep request after bus-off without auto-restart |
| flag_clear | output | 1 | Write-back pulse clearing the flag byte |

## Verification
The bench sweeps every one of the 256 flag values through a reduced 4-bit counter configuration. This catches a priority inversion, such as RX passive outranking TX passive, which would show up as a wrong level or a wrong detail bit. It also exposes a missing cascaded increment on an active-to-passive jump and counters that wrap to zero rather than holding at 15. Separate sequences cover the cases tied to bus-off and restart. A design that kept tracking while asleep would move its state or pulse `flag_clear`. One that forgot the pending restart would drop the restart-tagged event on a sample without `err_irq`. One that let a same-cycle sample win over a restart would leave the level non-zero.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    localparam int FLAG_W  = 8;
    localparam int DET_W   = 5;
    localparam int CLS_W   = 3;
    localparam int STEP_W  = 2;

    // flag byte bit positions (decoded by this block)
    localparam int FB_RXWARN = 1;
    localparam int FB_TXWARN = 2;
    localparam int FB_RXPASS = 3;
    localparam int FB_TXPASS = 4;
    localparam int FB_BUSOFF = 5;
    localparam int FB_OVF0   = 6;
    localparam int FB_OVF1   = 7;

    // detail bit positions
    localparam int DT_RXWARN = 0;
    localparam int DT_TXWARN = 1;
    localparam int DT_RXPASS = 2;
    localparam int DT_TXPASS = 3;
    localparam int DT_RXOVF  = 4;

    // class bit positions
    localparam int CL_CTRL    = 0;
    localparam int CL_BUSOFF  = 1;
    localparam int CL_RESTART = 2;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_WARNING = 2'd1,
        FC_PASSIVE = 2'd2,
        FC_BUSOFF  = 2'd3
    } fc_level_e;

    typedef struct packed {
        fc_level_e          level;
        logic               sleep;
        logic               rst_pend;
        logic               evt_valid;
        logic [CLS_W-1:0]   evt_class;
        logic [DET_W-1:0]   evt_detail;
        logic               clr;
    } fc_regs_t;

endpackage

// File: rtl/can_fc_prio.sv
module can_fc_prio
    import can_fc_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    output fc_level_e         level,
    output logic [DET_W-1:0]  detail
);

    logic [DET_W-1:0] cause;

    always_comb begin
        cause = '0;
        level = FC_ACTIVE;
        if (flags[FB_BUSOFF]) begin
            level = FC_BUSOFF;
        end else if (flags[FB_TXPASS]) begin
            level = FC_PASSIVE;
            cause[DT_TXPASS] = 1'b1;
        end else if (flags[FB_RXPASS]) begin
            level = FC_PASSIVE;
            cause[DT_RXPASS] = 1'b1;
        end else if (flags[FB_TXWARN]) begin
            level = FC_WARNING;
            cause[DT_TXWARN] = 1'b1;
        end else if (flags[FB_RXWARN]) begin
            level = FC_WARNING;
            cause[DT_RXWARN] = 1'b1;
        end
        cause[DT_RXOVF] = flags[FB_OVF0] | flags[FB_OVF1];
        detail = cause;
    end

endmodule

// File: rtl/can_fc_satcnt.sv
module can_fc_satcnt #(
    parameter int W      = 8,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step,
    output logic [W-1:0]      value
);

    localparam int              SUM_W = W + STEP_W;
    localparam logic [SUM_W-1:0] LIMIT = {{STEP_W{1'b0}}, {W{1'b1}}};

    logic [W-1:0]     cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {{STEP_W{1'b0}}, cnt_q} + {{W{1'b0}}, step};
        if (sum > LIMIT) begin
            cnt_d = {W{1'b1}};
        end else begin
            cnt_d = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q;

endmodule

// File: rtl/can_fc_tracker.sv
module can_fc_tracker
    import can_fc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_valid,
    input  logic [7:0]       flag_byte,
    input  logic             err_irq,
    input  logic             restart_req,
    input  logic             auto_restart_en,
    output logic [1:0]       bus_state,
    output logic [CNT_W-1:0] warn_cnt,
    output logic [CNT_W-1:0] pass_cnt,
    output logic [OVF_W-1:0] ovf_cnt,
    output logic             evt_valid,
    output logic [2:0]       evt_class,
    output logic [4:0]       evt_detail,
    output logic             sleep_req,
    output logic             flag_clear
);

    fc_regs_t          r_d, r_q;
    fc_level_e         enc_level;
    logic [DET_W-1:0]  enc_detail;
    logic              accept;
    logic [STEP_W-1:0] warn_step, pass_step, ovf_step;

    can_fc_prio u_prio (
        .flags  (flag_byte),
        .level  (enc_level),
        .detail (enc_detail)
    );

    always_comb begin
        r_d           = r_q;
        r_d.evt_valid = 1'b0;
        r_d.clr       = 1'b0;
        warn_step     = '0;
        pass_step     = '0;
        ovf_step      = '0;
        accept        = flag_valid && !r_q.sleep && !restart_req;

        if (restart_req) begin
            r_d.level    = FC_ACTIVE;
            r_d.sleep    = 1'b0;
            r_d.rst_pend = 1'b1;
        end else if (accept) begin
            r_d.level = enc_level;
            r_d.clr   = 1'b1;
            if (r_q.level == FC_ACTIVE && enc_level != FC_ACTIVE) begin
                warn_step = STEP_W'(1);
            end
            if ((r_q.level == FC_ACTIVE || r_q.level == FC_WARNING) &&
                (enc_level == FC_PASSIVE || enc_level == FC_BUSOFF)) begin
                pass_step = STEP_W'(1);
            end
            ovf_step = {1'b0, flag_byte[FB_OVF0]} + {1'b0, flag_byte[FB_OVF1]};
            if (err_irq || r_q.rst_pend) begin
                r_d.evt_valid               = 1'b1;
                r_d.evt_detail              = enc_detail;
                r_d.evt_class               = '0;
                r_d.evt_class[CL_RESTART]   = r_q.rst_pend;
                r_d.evt_class[CL_BUSOFF]    = (enc_level == FC_BUSOFF);
                r_d.evt_class[CL_CTRL]      = |enc_detail;
            end
            r_d.rst_pend = 1'b0;
            r_d.sleep    = (enc_level == FC_BUSOFF) && !auto_restart_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    can_fc_satcnt #(.W(CNT_W), .STEP_W(STEP_W)) u_warn_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (warn_step),
        .value (warn_cnt)
    );

    can_fc_satcnt #(.W(CNT_W), .STEP_W(STEP_W)) u_pass_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pass_step),
        .value (pass_cnt)
    );

    can_fc_satcnt #(.W(OVF_W), .STEP_W(STEP_W)) u_ovf_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ovf_step),
        .value (ovf_cnt)
    );

    assign bus_state  = r_q.level;
    assign evt_valid  = r_q.evt_valid;
    assign evt_class  = r_q.evt_class;
    assign evt_detail = r_q.evt_detail;
    assign sleep_req  = r_q.sleep;
    assign flag_clear = r_q.clr;

endmodule

// File: rtl/can_fc_tracker_chk.sv
module can_fc_tracker_chk #(
    parameter int CNT_W = 8,
    parameter int OVF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flag_valid,
    input logic             restart_req,
    input logic [1:0]       bus_state,
    input logic [CNT_W-1:0] warn_cnt,
    input logic [CNT_W-1:0] pass_cnt,
    input logic [OVF_W-1:0] ovf_cnt,
    input logic             sleep_req,
    input logic             flag_clear
);

    // R7
    a_r7_restart_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> (bus_state == 2'd0) && !sleep_req);

    // R9
    a_r9_frozen_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !restart_req) |=> sleep_req && $stable(bus_state) &&
            $stable(warn_cnt) && $stable(pass_cnt) && !flag_clear);

    // R8
    a_r8_clear_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clear |-> $past(flag_valid) && !$past(restart_req) && !$past(sleep_req));

    // R2
    a_r2_warn_on_leave_active: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warn_cnt) |-> ($past(bus_state) == 2'd0) && (bus_state != 2'd0));

    // R3
    a_r3_pass_on_enter_passive: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_cnt) |-> ($past(bus_state) <= 2'd1) && (bus_state >= 2'd2));

    // R5
    a_r5_warn_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_cnt == {CNT_W{1'b1}}) |=> (warn_cnt == {CNT_W{1'b1}}));

    // R5
    a_r5_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt == {OVF_W{1'b1}}) |=> (ovf_cnt == {OVF_W{1'b1}}));

endmodule

bind can_fc_tracker can_fc_tracker_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_valid  (flag_valid),
    .restart_req (restart_req),
    .bus_state   (bus_state),
    .warn_cnt    (warn_cnt),
    .pass_cnt    (pass_cnt),
    .ovf_cnt     (ovf_cnt),
    .sleep_req   (sleep_req),
    .flag_clear  (flag_clear)
);

// File: tb/can_fc_tracker_bench.sv
module can_fc_tracker_bench;

    localparam int CW   = 4;
    localparam int OW   = 4;
    localparam int CMAX = (1 << CW) - 1;
    localparam int OMAX = (1 << OW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flag_valid = 1'b0;
    logic [7:0]    flag_byte = '0;
    logic          err_irq = 1'b0;
    logic          restart_req = 1'b0;
    logic          auto_restart_en = 1'b1;
    logic [1:0]    bus_state;
    logic [CW-1:0] warn_cnt, pass_cnt;
    logic [OW-1:0] ovf_cnt;
    logic          evt_valid;
    logic [2:0]    evt_class;
    logic [4:0]    evt_detail;
    logic          sleep_req, flag_clear;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    // model
    int m_lvl, m_warn, m_pass, m_ovf;
    bit m_sleep, m_pend, x_evt, x_clr;
    int x_cls, x_det;

    always #10 clk = ~clk;

    can_fc_tracker #(.CNT_W(CW), .OVF_W(OW)) u_can_fc_tracker (
        .clk             (clk),
        .rst_n           (rst_n),
        .flag_valid      (flag_valid),
        .flag_byte       (flag_byte),
        .err_irq         (err_irq),
        .restart_req     (restart_req),
        .auto_restart_en (auto_restart_en),
        .bus_state       (bus_state),
        .warn_cnt        (warn_cnt),
        .pass_cnt        (pass_cnt),
        .ovf_cnt         (ovf_cnt),
        .evt_valid       (evt_valid),
        .evt_class       (evt_class),
        .evt_detail      (evt_detail),
        .sleep_req       (sleep_req),
        .flag_clear      (flag_clear)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_errors = n_errors + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lvl_of(input int f);
        if (f & 32)      return 3;
        else if (f & 16) return 2;
        else if (f & 8)  return 2;
        else if (f & 4)  return 1;
        else if (f & 2)  return 1;
        else             return 0;
    endfunction

    function automatic int det_of(input int f);
        int d;
        if (f & 32)      d = 0;
        else if (f & 16) d = 8;
        else if (f & 8)  d = 4;
        else if (f & 4)  d = 2;
        else if (f & 2)  d = 1;
        else             d = 0;
        if (f & 192) d = d + 16;
        return d;
    endfunction

    function automatic int sat(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction

    task automatic model_reset();
        m_lvl = 0; m_warn = 0; m_pass = 0; m_ovf = 0;
        m_sleep = 0; m_pend = 0; x_evt = 0; x_clr = 0; x_cls = 0; x_det = 0;
    endtask

    task automatic model_step(input bit fv, input int f, input bit irq, input bit rs);
        int nl;
        x_evt = 0; x_clr = 0;
        if (rs) begin
            m_lvl = 0; m_sleep = 0; m_pend = 1;
        end else if (fv && !m_sleep) begin
            nl = lvl_of(f);
            if (m_lvl == 0 && nl != 0) m_warn = sat(m_warn + 1, CMAX);
            if (m_lvl <= 1 && nl >= 2) m_pass = sat(m_pass + 1, CMAX);
            m_ovf = sat(m_ovf + ((f >> 6) & 1) + ((f >> 7) & 1), OMAX);
            if (irq || m_pend) begin
                x_evt = 1;
                x_det = det_of(f);
                x_cls = (m_pend ? 4 : 0) + ((nl == 3) ? 2 : 0) + ((x_det != 0) ? 1 : 0);
            end
            m_pend = 0;
            x_clr = 1;
            m_sleep = (nl == 3) && !auto_restart_en;
            m_lvl = nl;
        end
    endtask

    task automatic check_all();
        chk("R1 level", bus_state, m_lvl);
        chk((m_warn == CMAX) ? "R5 warn saturation" : "R2 warn count", warn_cnt, m_warn);
        chk((m_pass == CMAX) ? "R5 pass saturation" : "R3 pass count", pass_cnt, m_pass);
        chk((m_ovf == OMAX) ? "R5 ovf saturation" : "R4 ovf count", ovf_cnt, m_ovf);
        chk(m_pend ? "R7 no event on restart" : "R6 event strobe", evt_valid, x_evt);
        if (x_evt) begin
            chk((x_cls & 4) ? "R7 restart class" : "R6 event class", evt_class, x_cls);
            chk("R6 event detail", evt_detail, x_det);
        end
        chk("R8 flag clear", flag_clear, x_clr);
        chk(auto_restart_en ? "R10 no sleep" : "R9 sleep", sleep_req, m_sleep);
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic cyc(input bit fv, input int f, input bit irq, input bit rs);
        flag_valid = fv; flag_byte = f[7:0]; err_irq = irq; restart_req = rs;
        model_step(fv, f, irq, rs);
        @(negedge clk);
        flag_valid = 0; err_irq = 0; restart_req = 0;
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        // reset state
        auto_restart_en = 1;
        do_reset();

        // R3: one jump active -> RX passive bumps both counters, detail RX passive
        cyc(1, 8'h08, 1, 0);
        cyc(0, 0, 0, 0);
        // R1: TX passive outranks RX passive
        cyc(1, 8'h18, 1, 0);
        // back to active, then RX warning with both overflow bits (R4)
        cyc(1, 8'h00, 0, 0);
        cyc(1, 8'hC2, 1, 0);

        // exhaustive sweep of flag values with auto-restart on (R1..R6, R8, R10)
        for (int f = 0; f < 256; f++) begin
            cyc(1, f, f[0] ^ f[4], 0);
            cyc(1, (f * 37) & 8'h3E, 0, 0);
            cyc(0, 0, 1, 0);
        end

        // R9 / R7 sequence with auto-restart off
        auto_restart_en = 0;
        do_reset();
        cyc(1, 8'h04, 1, 0);          // warning
        cyc(1, 8'h20, 1, 0);          // bus-off -> sleep (R9)
        cyc(1, 8'h00, 1, 0);          // ignored (R9)
        cyc(1, 8'hC2, 1, 0);          // ignored, overflow not counted (R9)
        cyc(1, 8'h10, 1, 1);          // restart, same-cycle sample ignored (R7)
        cyc(0, 0, 0, 0);
        cyc(1, 8'h00, 0, 0);          // restart-tagged event without err_irq (R7)
        cyc(1, 8'h00, 0, 0);          // no further event (R6)
        cyc(1, 8'h08, 0, 1);          // restart while active
        cyc(1, 8'h20, 0, 0);          // restart + bus-off class, sleep again
        cyc(1, 8'h02, 1, 1);          // restart releases sleep (R7)
        cyc(1, 8'h02, 0, 0);

        // R10: bus-off with auto-restart on keeps tracking
        auto_restart_en = 1;
        do_reset();
        cyc(1, 8'h20, 1, 0);
        cyc(1, 8'h20, 0, 0);
        cyc(1, 8'h00, 1, 0);
        cyc(1, 8'h04, 0, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule